// File: doc/BRIEF.md
# First-Fit Two-Pin Net Router

This block assigns switches to a stream of two-pin nets inside a switch core. The core has `NUM_SIDES` sides with `TRACKS` terminals on each side. Between any two different sides there is a switch joining track `j` on one side to track `t` on the other whenever `|j - t| <= 1`. Each incoming request names two sides. The router keeps a map of which terminals are taken and picks the first switch whose two terminals are both free. It then reports the chosen track pair, or a status code that says why no switch was taken. Every switch it closes sets one bit of a configuration vector that drives the fabric.

Requests arrive on a valid/ready stream and results leave on a second valid/ready stream. An input item transfers on a rising edge where `in_valid` and `in_ready` are both high. An output item transfers on a rising edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, a pending result stays on the output unchanged, and the router keeps accepting input until its single internal stage is full. The upstream logic is responsible for the order of the nets. When that order keeps the net counts of the two named sides within one of each other at every step, every net is placed. A synchronous `clr` pulse empties the terminal map, the per-side counts and the configuration vector, ready for a new job.

Top module: `net_router_core`

## Requirements
- R1: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and every result field holds its value. `in_ready` is low only during `clr`, or when the internal stage is full and the output is stalled.
- R2: A result reports the smaller of the two requested side numbers on `out_side_lo` and the larger on `out_side_hi`. Each result track belongs to the side reported beside it.
- R3: A request that names the same side twice returns status SKIP (2). It leaves the terminal map and the configuration vector unchanged.
- R4: A request is rejected with status REJECT (3), and changes no state, in two cases: a side number is `NUM_SIDES` or larger, or either side already carries `TRACKS` nets. An out-of-range side takes priority over SKIP.
- R5: Tracks are numbered 0 to `TRACKS-1`. The search tries each track `j` of the lower side in ascending order. For each `j` it tries the higher side's tracks in the order `j-1`, `j`, `j+1`, skipping any that lie outside the valid range. The first pair with both terminals free is chosen and returned with status PLACED (0).
- R6: When no switch with two free terminals exists, the result is status NOFIT (1) and no state changes.
- R7: If, for every accepted net, the nets already placed on its two sides differ in number by at most one, every net is returned PLACED.
- R8: A placement sets configuration bit `P*(3*TRACKS-2) + 2*j + t`. Here `j` is the lower-side track, `t` is the higher-side track, and `P = lo*(2*NUM_SIDES-lo-1)/2 + (hi-lo-1)` numbers the side pair.
- R9: A cycle with `clr` high clears all terminals, all side counts and every configuration bit. It is applied only while no request is in flight.
- R10: With `out_ready` held high, a request accepted at one rising edge has its result on the output right after the next rising edge.
- R11: After reset, `out_valid` is low, `in_ready` is high and `cfg_bits` is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous job clear |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request ready |
| in_side_a | input | SIDE_W | First side of the net |
| in_side_b | input | SIDE_W | Second side of the net |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result ready |
| out_side_lo | output | SIDE_W | Smaller side number |
| out_side_hi | output | SIDE_W | Larger side number |
| out_trk_lo | output | TRK_W | Track chosen on the lower side |
| out_trk_hi | output | TRK_W | Track chosen on the higher side |
| out_status | output | 2 | 0 PLACED, 1 NOFIT, 2 SKIP, 3 REJECT |
| cfg_bits | output | NUM_SW | Closed-switch configuration vector |

## Verification
The assertions take two things for granted about the inputs. First, `clr` is raised only when no request waits in the internal stage. Second, the upstream side never withdraws a request in a way that matters to the occupancy checks, because state changes only on an actual placement. The stimulus meets these conditions: it waits for every expected result to drain before it pulses `clr`, and it holds each request until it is accepted. Random side numbers, including out-of-range ones, and random output stalls exercise the back-pressure path. The order-dependent guarantee is tested with a hand-built balanced sequence.

// File: rtl/nr_pkg.sv
package nr_pkg;

  typedef enum logic [1:0] {
    ST_PLACED = 2'd0,
    ST_NOFIT  = 2'd1,
    ST_SKIP   = 2'd2,
    ST_REJECT = 2'd3
  } nr_status_e;

  // index of the unordered side pair (lo < hi) among all pairs
  function automatic int nr_pair_index(input int lo, input int hi, input int sides);
    return (lo * (2 * sides - lo - 1)) / 2 + (hi - lo - 1);
  endfunction

  // configuration bit of switch (lo track tl, hi track th)
  function automatic int nr_cfg_index(input int lo, input int hi, input int tl,
                                      input int th, input int sides, input int tracks);
    return nr_pair_index(lo, hi, sides) * (3 * tracks - 2) + 2 * tl + th;
  endfunction

endpackage

// File: rtl/nr_ingress.sv
module nr_ingress #(
  parameter int NUM_SIDES = 7,
  parameter int SIDE_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              advance,
  input  logic [SIDE_W-1:0] side_a,
  input  logic [SIDE_W-1:0] side_b,
  output logic              s1_valid,
  output logic [SIDE_W-1:0] s1_lo,
  output logic [SIDE_W-1:0] s1_hi,
  output logic              s1_skip,
  output logic              s1_bad
);

  logic [SIDE_W-1:0] lo_c, hi_c;
  logic              skip_c, bad_c;

  always_comb begin
    if (side_a < side_b) begin
      lo_c = side_a;
      hi_c = side_b;
    end else begin
      lo_c = side_b;
      hi_c = side_a;
    end
    skip_c = (side_a == side_b);
    bad_c  = (int'(side_a) >= NUM_SIDES) || (int'(side_b) >= NUM_SIDES);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
    end else if (accept) begin
      s1_valid <= 1'b1;
    end else if (advance) begin
      s1_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_lo   <= '0;
      s1_hi   <= '0;
      s1_skip <= 1'b0;
      s1_bad  <= 1'b0;
    end else if (accept) begin
      s1_lo   <= lo_c;
      s1_hi   <= hi_c;
      s1_skip <= skip_c;
      s1_bad  <= bad_c;
    end
  end

  // R2: a held net that is neither skipped nor rejected has ordered sides
  a_r2_lo_below_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_skip && !s1_bad) |-> (s1_lo < s1_hi));

endmodule

// File: rtl/nr_track_search.sv
module nr_track_search #(
  parameter int TRACKS = 3,
  parameter int TRK_W  = 2
) (
  input  logic [TRACKS-1:0] row_lo,
  input  logic [TRACKS-1:0] row_hi,
  output logic              found,
  output logic [TRK_W-1:0]  trk_lo,
  output logic [TRK_W-1:0]  trk_hi
);

  // higher-side row padded with taken terminals at track -1 and track TRACKS
  logic [TRACKS+1:0] hi_pad;
  assign hi_pad = {1'b1, row_hi, 1'b1};

  always_comb begin
    found  = 1'b0;
    trk_lo = '0;
    trk_hi = '0;
    for (int j = 0; j < TRACKS; j++) begin
      for (int m = 0; m < 3; m++) begin
        if (!found && !row_lo[j] && !hi_pad[j + m]) begin
          found  = 1'b1;
          trk_lo = TRK_W'(j);
          trk_hi = TRK_W'(j + m - 1);
        end
      end
    end
  end

endmodule

// File: rtl/nr_occupancy.sv
module nr_occupancy
  import nr_pkg::*;
#(
  parameter int NUM_SIDES = 7,
  parameter int TRACKS    = 3,
  parameter int SIDE_W    = 3,
  parameter int TRK_W     = 2,
  parameter int NUM_SW    = 147,
  localparam int CNT_W    = $clog2(TRACKS + 1),
  localparam int CFG_IW   = (NUM_SW > 1) ? $clog2(NUM_SW) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd_en,
  input  logic [SIDE_W-1:0] upd_lo,
  input  logic [SIDE_W-1:0] upd_hi,
  input  logic [TRK_W-1:0]  upd_tl,
  input  logic [TRK_W-1:0]  upd_th,
  input  logic [SIDE_W-1:0] rd_lo,
  input  logic [SIDE_W-1:0] rd_hi,
  output logic [TRACKS-1:0] row_lo,
  output logic [TRACKS-1:0] row_hi,
  output logic              full_lo,
  output logic              full_hi,
  output logic [NUM_SW-1:0] cfg_bits
);

  logic [NUM_SIDES-1:0][TRACKS-1:0] occ_w;
  logic [NUM_SIDES-1:0][CNT_W-1:0]  cnt_w;
  logic [NUM_SW-1:0]                cfg_q;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    logic [TRACKS-1:0] occ_r;
    logic [CNT_W-1:0]  cnt_r;
    logic              hit_lo, hit_hi;
    logic [TRK_W-1:0]  trk;

    assign hit_lo = upd_en && (int'(upd_lo) == s);
    assign hit_hi = upd_en && (int'(upd_hi) == s);
    assign trk    = hit_lo ? upd_tl : upd_th;

    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        occ_r <= '0;
        cnt_r <= '0;
      end else if (hit_lo || hit_hi) begin
        occ_r <= occ_r | (TRACKS'(1) << trk);
        cnt_r <= cnt_r + CNT_W'(1);
      end
    end

    assign occ_w[s] = occ_r;
    assign cnt_w[s] = cnt_r;

    // R4: the side counter always agrees with the terminals taken on that side
    a_r4_count_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_r == CNT_W'($countones(occ_r)));
  end

  logic [SIDE_W-1:0] rl, rh;
  assign rl = (int'(rd_lo) < NUM_SIDES) ? rd_lo : '0;
  assign rh = (int'(rd_hi) < NUM_SIDES) ? rd_hi : '0;

  assign row_lo  = occ_w[rl];
  assign row_hi  = occ_w[rh];
  assign full_lo = (cnt_w[rl] == CNT_W'(TRACKS));
  assign full_hi = (cnt_w[rh] == CNT_W'(TRACKS));

  logic [CFG_IW-1:0] bit_idx;
  assign bit_idx = CFG_IW'(nr_cfg_index(int'(upd_lo), int'(upd_hi), int'(upd_tl),
                                        int'(upd_th), NUM_SIDES, TRACKS));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cfg_q <= '0;
    end else if (upd_en) begin
      cfg_q <= cfg_q | (NUM_SW'(1) << bit_idx);
    end
  end

  assign cfg_bits = cfg_q;

  // R6: a placement only ever takes two terminals that were free
  a_r6_fresh_terminals: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> (!occ_w[upd_lo][upd_tl] && !occ_w[upd_hi][upd_th]));

  // R9: a clear cycle leaves an empty map and vector
  a_r9_clear_wipes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cfg_q == '0 && occ_w == '0));

  // R3: without a placement or a clear nothing in the state moves
  a_r3_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en && !clr) |=> ($stable(cfg_q) && $stable(occ_w)));

endmodule

// File: rtl/net_router_core.sv
module net_router_core
  import nr_pkg::*;
#(
  parameter int NUM_SIDES = 7,
  parameter int TRACKS    = 3,
  localparam int SIDE_W   = (NUM_SIDES > 1) ? $clog2(NUM_SIDES + 1) : 1,
  localparam int TRK_W    = (TRACKS > 1) ? $clog2(TRACKS) : 1,
  localparam int NUM_SW   = (NUM_SIDES * (NUM_SIDES - 1) / 2) * (3 * TRACKS - 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SIDE_W-1:0] in_side_a,
  input  logic [SIDE_W-1:0] in_side_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SIDE_W-1:0] out_side_lo,
  output logic [SIDE_W-1:0] out_side_hi,
  output logic [TRK_W-1:0]  out_trk_lo,
  output logic [TRK_W-1:0]  out_trk_hi,
  output logic [1:0]        out_status,
  output logic [NUM_SW-1:0] cfg_bits
);

  logic              s1_valid, s1_skip, s1_bad;
  logic [SIDE_W-1:0] s1_lo, s1_hi;
  logic              out_free, accept, advance;

  assign out_free = !out_valid || out_ready;
  assign advance  = s1_valid && out_free;
  assign in_ready = (!s1_valid || out_free) && !clr;
  assign accept   = in_valid && in_ready;

  nr_ingress #(.NUM_SIDES(NUM_SIDES), .SIDE_W(SIDE_W)) u_ingress (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .advance  (advance),
    .side_a   (in_side_a),
    .side_b   (in_side_b),
    .s1_valid (s1_valid),
    .s1_lo    (s1_lo),
    .s1_hi    (s1_hi),
    .s1_skip  (s1_skip),
    .s1_bad   (s1_bad)
  );

  logic [TRACKS-1:0] row_lo, row_hi;
  logic              full_lo, full_hi;
  logic              found;
  logic [TRK_W-1:0]  fit_lo, fit_hi;
  logic              upd_en;
  nr_status_e        st_c;

  nr_track_search #(.TRACKS(TRACKS), .TRK_W(TRK_W)) u_search (
    .row_lo (row_lo),
    .row_hi (row_hi),
    .found  (found),
    .trk_lo (fit_lo),
    .trk_hi (fit_hi)
  );

  always_comb begin
    if (s1_bad)                 st_c = ST_REJECT;
    else if (s1_skip)           st_c = ST_SKIP;
    else if (full_lo || full_hi) st_c = ST_REJECT;
    else if (found)             st_c = ST_PLACED;
    else                        st_c = ST_NOFIT;
  end

  assign upd_en = advance && (st_c == ST_PLACED);

  nr_occupancy #(
    .NUM_SIDES (NUM_SIDES),
    .TRACKS    (TRACKS),
    .SIDE_W    (SIDE_W),
    .TRK_W     (TRK_W),
    .NUM_SW    (NUM_SW)
  ) u_occ (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .upd_en   (upd_en),
    .upd_lo   (s1_lo),
    .upd_hi   (s1_hi),
    .upd_tl   (fit_lo),
    .upd_th   (fit_hi),
    .rd_lo    (s1_lo),
    .rd_hi    (s1_hi),
    .row_lo   (row_lo),
    .row_hi   (row_hi),
    .full_lo  (full_lo),
    .full_hi  (full_hi),
    .cfg_bits (cfg_bits)
  );

  nr_status_e out_st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_side_lo <= '0;
      out_side_hi <= '0;
      out_trk_lo  <= '0;
      out_trk_hi  <= '0;
      out_st_q    <= ST_PLACED;
    end else if (advance) begin
      out_valid   <= 1'b1;
      out_side_lo <= s1_lo;
      out_side_hi <= s1_hi;
      out_trk_lo  <= (st_c == ST_PLACED) ? fit_lo : '0;
      out_trk_hi  <= (st_c == ST_PLACED) ? fit_hi : '0;
      out_st_q    <= st_c;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  assign out_status = out_st_q;

  // R1: a stalled result is held
  a_r1_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_side_lo) && $stable(out_side_hi)
      && $stable(out_trk_lo) && $stable(out_trk_hi) && $stable(out_status)));

  // R5: a placed result uses neighbouring tracks on two ordered sides
  a_r5_neighbour_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_status == 2'd0) |->
      ((out_side_lo < out_side_hi) &&
       ((out_trk_lo == out_trk_hi) || (out_trk_lo + TRK_W'(1) == out_trk_hi)
        || (out_trk_hi + TRK_W'(1) == out_trk_lo))));

  // R9: a clear is only issued with no request in flight
  a_r9_clear_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !s1_valid);

  // R10: a held request reaches the output at the next free edge
  a_r10_issue_next: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && out_free) |=> out_valid);

endmodule

// File: tb/tb_net_router_core.sv
`timescale 1ns/1ps
module tb_net_router_core;

  localparam int K  = 7;
  localparam int R  = 3;
  localparam int NS = (K * (K - 1) / 2) * (3 * R - 2);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [2:0]    in_side_a = '0, in_side_b = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [2:0]    out_side_lo, out_side_hi;
  logic [1:0]    out_trk_lo, out_trk_hi;
  logic [1:0]    out_status;
  logic [NS-1:0] cfg_bits;

  always #2 clk = ~clk;

  net_router_core #(.NUM_SIDES(K), .TRACKS(R)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_side_a(in_side_a), .in_side_b(in_side_b),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_side_lo(out_side_lo), .out_side_hi(out_side_hi),
    .out_trk_lo(out_trk_lo), .out_trk_hi(out_trk_hi),
    .out_status(out_status), .cfg_bits(cfg_bits)
  );

  typedef struct {
    int    lo, hi, tl, th, st;
    bit    must_place;
    string tag;
  } exp_t;

  exp_t    q[$];
  int      checks = 0;
  int      failures = 0;
  int      ready_mode = 0;
  bit      m_occ[K][R];
  int      m_cnt[K];
  bit [NS-1:0] m_cfg;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  function automatic void model_clear();
    for (int s = 0; s < K; s++) begin
      m_cnt[s] = 0;
      for (int t = 0; t < R; t++) m_occ[s][t] = 1'b0;
    end
    m_cfg = '0;
  endfunction

  // reference placement from the requirements
  function automatic exp_t model(input int a, input int b);
    exp_t e;
    bit   done;
    e.lo = (a < b) ? a : b;
    e.hi = (a < b) ? b : a;
    e.tl = 0; e.th = 0; e.must_place = 1'b0; e.tag = "R5";
    if (e.hi >= K) begin
      e.st = 3; e.tag = "R4";
    end else if (a == b) begin
      e.st = 2; e.tag = "R3";
    end else if (m_cnt[e.lo] == R || m_cnt[e.hi] == R) begin
      e.st = 3; e.tag = "R4";
    end else begin
      done = 1'b0;
      e.st = 1;
      for (int j = 0; j < R; j++) begin
        for (int t = j - 1; t <= j + 1; t++) begin
          if (!done && t >= 0 && t < R && !m_occ[e.lo][j] && !m_occ[e.hi][t]) begin
            done = 1'b1; e.tl = j; e.th = t; e.st = 0;
          end
        end
      end
      if (done) begin
        m_occ[e.lo][e.tl] = 1'b1;
        m_occ[e.hi][e.th] = 1'b1;
        m_cnt[e.lo]++;
        m_cnt[e.hi]++;
        m_cfg[((e.lo * (2 * K - e.lo - 1)) / 2 + (e.hi - e.lo - 1)) * (3 * R - 2)
              + 2 * e.tl + e.th] = 1'b1;
      end else begin
        e.tag = "R6";
      end
    end
    return e;
  endfunction

  task automatic drive(input int a, input int b);
    @(negedge clk);
    in_valid  = 1'b1;
    in_side_a = 3'(a);
    in_side_b = 3'(b);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic send(input int a, input int b, input bit must);
    exp_t e;
    e = model(a, b);
    e.must_place = must;
    if (must) e.tag = "R7";
    q.push_back(e);
    drive(a, b);
  endtask

  task automatic send_hand(input int a, input int b, input int st, input int tl,
                           input int th, input string tag);
    exp_t e, d;
    d = model(a, b);
    e.lo = (a < b) ? a : b;
    e.hi = (a < b) ? b : a;
    e.st = st; e.tl = tl; e.th = th; e.must_place = 1'b0; e.tag = tag;
    q.push_back(e);
    drive(a, b);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_clear();
    drain();
    @(negedge clk);
    clr = 1'b1;
    @(posedge clk);
    #1 clr = 1'b0;
    model_clear();
  endtask

  task automatic check_cfg(input string tag);
    @(negedge clk);
    check(cfg_bits == m_cfg, tag, "cfg_bits ones", $countones(cfg_bits), $countones(m_cfg));
  endtask

  // output ready pattern, changed just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      case (ready_mode)
        0: out_ready = 1'b1;
        1: out_ready = 1'($urandom % 2);
        default: out_ready = 1'b0;
      endcase
    end
  end

  // scoreboard monitor
  initial begin
    exp_t e;
    bit   ok;
    forever begin
      @(negedge clk);
      if (rst_n && out_valid && out_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R1", "unexpected result status", out_status, -1);
        end else begin
          e = q.pop_front();
          ok = (int'(out_status) == e.st) && (int'(out_side_lo) == e.lo)
               && (int'(out_side_hi) == e.hi);
          if (e.st == 0)
            ok = ok && (int'(out_trk_lo) == e.tl) && (int'(out_trk_hi) == e.th);
          check(ok, e.tag, "status/sides/tracks",
                {out_status, out_side_lo, out_side_hi, out_trk_lo, out_trk_hi},
                {2'(e.st), 3'(e.lo), 3'(e.hi), 2'(e.tl), 2'(e.th)});
          if (e.must_place)
            check(out_status == 2'd0, "R7", "balanced net placed", out_status, 0);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  logic [11:0] held;

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R11", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R11", "in_ready after reset", in_ready, 1);
    check(cfg_bits == '0, "R11", "cfg ones after reset", $countones(cfg_bits), 0);

    // R10 latency with the output always ready
    send_hand(5, 6, 0, 0, 0, "R5");
    @(negedge clk);
    check(out_valid == 1'b0, "R10", "out_valid one edge after accept", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R10", "out_valid two edges after accept", out_valid, 1);

    // hand-traced first-fit sequence
    send_hand(6, 5, 0, 1, 1, "R2");
    send_hand(3, 5, 0, 1, 2, "R5");
    send_hand(3, 6, 0, 2, 2, "R5");
    send_hand(0, 1, 0, 0, 0, "R5");
    send_hand(0, 1, 0, 1, 1, "R5");
    send_hand(0, 3, 1, 0, 0, "R6");
    send_hand(5, 2, 3, 0, 0, "R4");
    send_hand(4, 4, 2, 0, 0, "R3");
    send_hand(6, 7, 3, 0, 0, "R4");
    send_hand(7, 7, 3, 0, 0, "R4");
    send_hand(2, 4, 0, 0, 0, "R3");
    send_hand(0, 2, 0, 2, 1, "R6");
    drain();
    check(cfg_bits[140] && cfg_bits[143] && cfg_bits[116] && cfg_bits[125],
          "R8", "pair 5-6 and 3-x bits", cfg_bits[143:116], 1);
    check(cfg_bits[0] && cfg_bits[3] && cfg_bits[84] && cfg_bits[12],
          "R8", "pair 0-1, 2-4, 0-2 bits", {cfg_bits[84], cfg_bits[12], cfg_bits[3], cfg_bits[0]}, 15);
    check($countones(cfg_bits) == 8, "R8", "closed switch count", $countones(cfg_bits), 8);
    check_cfg("R8");

    // R1 back-pressure
    ready_mode = 2;
    @(negedge clk);
    out_ready = 1'b0;
    send(1, 3, 1'b0);
    repeat (3) @(negedge clk);
    held = {out_status, out_side_lo, out_side_hi, out_trk_lo, out_trk_hi};
    check(out_valid == 1'b1, "R1", "result pending while stalled", out_valid, 1);
    send(2, 6, 1'b0);
    @(negedge clk);
    check(in_ready == 1'b0, "R1", "in_ready with full stage and stall", in_ready, 0);
    check({out_status, out_side_lo, out_side_hi, out_trk_lo, out_trk_hi} == held,
          "R1", "stalled result held", {out_status, out_side_lo, out_side_hi, out_trk_lo, out_trk_hi}, held);
    ready_mode = 0;
    drain();

    // R9 clear
    do_clear();
    @(negedge clk);
    check(cfg_bits == '0, "R9", "cfg ones after clear", $countones(cfg_bits), 0);
    send_hand(5, 6, 0, 0, 0, "R9");

    // R7 balanced order
    do_clear();
    send(0, 1, 1'b1); send(1, 2, 1'b1); send(2, 3, 1'b1); send(3, 4, 1'b1);
    send(4, 5, 1'b1); send(5, 6, 1'b1); send(6, 0, 1'b1); send(0, 2, 1'b1);
    send(1, 3, 1'b1); send(4, 6, 1'b1);
    drain();
    check_cfg("R8");

    // random traffic under random back-pressure
    for (int round = 0; round < 3; round++) begin
      do_clear();
      ready_mode = 1;
      for (int n = 0; n < 40; n++) begin
        int a, b;
        a = ($urandom % 10 == 0) ? 7 : int'($urandom_range(0, K - 1));
        b = int'($urandom_range(0, K - 1));
        send(a, b, 1'b0);
      end
      ready_mode = 0;
      drain();
      check_cfg("R8");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule